// File: doc/BRIEF.md
# Prioritized Event Code Arbiter

This block gathers trigger pulses from a row of external inputs and from a queue of events loaded by software. It hands one event code at a time to a downstream link serializer over a valid/ready handshake. Each trigger input is synchronized and edge detected, then held in a per-input pending latch until the output stage takes it. When several inputs are pending, the input with the lowest index goes first. Each input position is mapped to its transmitted 8-bit code through a writable table, so the codes can be reassigned without touching the receivers.

Hardware inputs must map into the lower part of the code space, and software events must use the upper part. A bad table entry, a bad software code, or a retrigger on an input that is still pending each sets its own sticky error bit. Once the configured pre-pulse code has been accepted downstream, a lockout window opens. In that window, inputs at or above a programmed index and all queued software events are held back until the configured extraction code has been accepted.

Top module: `evt_prio_arbiter`

## Requirements
- R1: After reset, `ev_valid` is low, the queue reads empty and not full, the lockout bit and all three error bits are low, and table entry i (read at cfg address i, 0..63) holds code i.
- R2: A rising edge on `trig_in[i]` produces exactly one event carrying the code in table entry i, even if the input then stays high.
- R3: When several inputs are pending, their events leave in ascending input index order.
- R4: Writing cfg address i (0..63) replaces the code that input i sends from then on.
- R5: If an input's table code is 64 or more, that event is dropped, its pending latch clears, and `err_range` (error register bit 0) is set.
- R6: A write to cfg address 0x40 with data 64..255 queues that code. Queued codes leave in write order, and only when no eligible input is pending.
- R7: A write to cfg address 0x40 with data below 64 is discarded, and `err_fifo_val` (error register bit 1) is set.
- R8: The queue holds 16 codes. `fifo_full` and `fifo_empty` follow the fill level in real time, and a write while full is ignored.
- R9: After the code in cfg 0x42 (pre-pulse) is accepted, `lockout_active` rises. Inputs with index at or above cfg 0x41 and all queued codes are then held until the code in cfg 0x43 (extraction) is accepted. Inputs below the boundary still pass during the window.
- R10: A new rising edge on an input whose event is still pending sets `err_lost` (error register bit 2), and no second event is produced for it.
- R11: Each error bit stays set until a cfg write to 0x44 with a 1 in that bit position. Writing 0 leaves it unchanged.
- R12: While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high and `ev_code` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 64 | Asynchronous trigger inputs, index 0 highest priority |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address for write and read |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` (0x45 gives {lockout, full, empty} in bits 2..0) |
| ev_valid | output | 1 | Event code available |
| ev_code | output | 8 | Event code to the serializer |
| ev_ready | input | 1 | Serializer accepts the code |
| lockout_active | output | 1 | Pre-pulse to extraction window is open |
| fifo_full | output | 1 | Software queue full |
| fifo_empty | output | 1 | Software queue empty |
| err_range | output | 1 | Sticky: table code out of hardware range |
| err_fifo_val | output | 1 | Sticky: software code below 64 |
| err_lost | output | 1 | Sticky: retrigger while pending |

## Verification
A pending latch stuck at 1 shows up within a few cycles as a repeated event. A stuck-at-0 latch shows up as a missing event about four cycles after the trigger edge. A wrong priority order or a stale table entry shows up as a wrong `ev_code` at the next handshake. A lockout flag that is set or cleared one acceptance early or late shows up directly: a low-priority input or a queued code appears before the extraction code, or stays blocked after it. A wrong queue pointer shows up as a reordered, duplicated or lost code once the queue is drained, and a bad fill count shows up as a misreported full or empty flag.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;
    localparam int CODE_W = 8;
    typedef logic [CODE_W-1:0] code_t;

    // error register layout: bit2 lost, bit1 fifo value, bit0 range
    typedef struct packed {
        logic lost;
        logic fval;
        logic range;
    } err_t;
endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.s3;

    for (genvar gi = 0; gi < N; gi++) begin : g_chk
        AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            rise[gi] |=> !rise[gi]); // R2
    end
endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [N-1:0] below;

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    always_comb begin
        below = (N'(1) << idx) - N'(1);
        if (found) begin
            AST_PICK_FIRST: assert (((req & below) == '0) && req[idx]); // R3
        end
    end
endmodule

// File: rtl/evt_msg_fifo.sv
module evt_msg_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW:0]             wp;
        logic [PW:0]             rp;
    } st_t;

    st_t st_q, st_d;

    assign empty = (st_q.wp == st_q.rp);
    assign full  = (st_q.wp[PW] != st_q.rp[PW]) &&
                   (st_q.wp[PW-1:0] == st_q.rp[PW-1:0]);
    assign dout  = st_q.mem[st_q.rp[PW-1:0]];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp[PW-1:0]] = din;
            st_d.wp = st_q.wp + (PW+1)'(1);
        end
        if (pop) st_d.rp = st_q.rp + (PW+1)'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R6
endmodule

// File: rtl/evt_prio_arbiter.sv
module evt_prio_arbiter
    import evt_arb_pkg::*;
#(
    parameter int    N_IN          = 64,
    parameter int    FIFO_DEPTH    = 16,
    parameter int    ADDR_W        = 8,
    parameter int    HW_CODE_LIMIT = 64,
    parameter code_t PP_CODE_RST   = 8'hFE,
    parameter code_t EXT_CODE_RST  = 8'hFF,
    parameter code_t BOUND_RST     = 8'd32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   trig_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              ev_valid,
    output logic [7:0]        ev_code,
    input  logic              ev_ready,
    output logic              lockout_active,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              err_range,
    output logic              err_fifo_val,
    output logic              err_lost
);
    localparam int IDX_W = $clog2(N_IN);
    localparam code_t HW_LIM = code_t'(HW_CODE_LIMIT);
    localparam logic [ADDR_W-1:0] A_TBL_END = ADDR_W'(N_IN);
    localparam logic [ADDR_W-1:0] A_FIFO  = ADDR_W'(N_IN);
    localparam logic [ADDR_W-1:0] A_BOUND = ADDR_W'(N_IN + 1);
    localparam logic [ADDR_W-1:0] A_PP    = ADDR_W'(N_IN + 2);
    localparam logic [ADDR_W-1:0] A_EXT   = ADDR_W'(N_IN + 3);
    localparam logic [ADDR_W-1:0] A_ERR   = ADDR_W'(N_IN + 4);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(N_IN + 5);

    typedef struct packed {
        logic [N_IN-1:0][CODE_W-1:0] tbl;
        logic [N_IN-1:0]             pend;
        logic                        out_v;
        code_t                       out_code;
        logic                        lock;
        code_t                       bound;
        code_t                       pp;
        code_t                       ext;
        err_t                        err;
    } st_t;

    st_t st_q, st_d;

    logic [N_IN-1:0]  rise, low_mask, elig, take;
    logic             pick_found, hs, slot_free, lock_eff;
    logic [IDX_W-1:0] pick_idx;
    logic             fifo_push, fifo_pop, f_full, f_empty;
    code_t            fifo_dout;
    logic             clr_lost;

    evt_sync_edge #(.N(N_IN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .rise     (rise)
    );

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_mask
        assign low_mask[gi] = (code_t'(gi) < st_q.bound);
    end

    assign hs        = st_q.out_v & ev_ready;
    assign slot_free = ~st_q.out_v | ev_ready;

    always_comb begin
        lock_eff = st_q.lock;
        if (hs) begin
            if (st_q.out_code == st_q.ext)     lock_eff = 1'b0;
            else if (st_q.out_code == st_q.pp) lock_eff = 1'b1;
        end
        elig = lock_eff ? (st_q.pend & low_mask) : st_q.pend;
    end

    evt_prio_pick #(.N(N_IN), .IDX_W(IDX_W)) u_pick (
        .req   (elig),
        .found (pick_found),
        .idx   (pick_idx)
    );

    evt_msg_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (cfg_wdata),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .full  (f_full),
        .empty (f_empty)
    );

    always_comb begin
        st_d      = st_q;
        fifo_push = 1'b0;
        fifo_pop  = 1'b0;
        take      = '0;

        // software clears first so that a same-cycle set wins
        if (cfg_we && cfg_addr == A_ERR) begin
            st_d.err = st_q.err & ~err_t'(cfg_wdata[2:0]);
        end

        if (cfg_we) begin
            if (cfg_addr < A_TBL_END) begin
                st_d.tbl[cfg_addr[IDX_W-1:0]] = cfg_wdata;
            end else if (cfg_addr == A_FIFO) begin
                if (cfg_wdata < HW_LIM) st_d.err.fval = 1'b1;
                else if (!f_full)       fifo_push     = 1'b1;
            end else if (cfg_addr == A_BOUND) begin
                st_d.bound = cfg_wdata;
            end else if (cfg_addr == A_PP) begin
                st_d.pp = cfg_wdata;
            end else if (cfg_addr == A_EXT) begin
                st_d.ext = cfg_wdata;
            end
        end

        st_d.lock = lock_eff;
        if (hs) st_d.out_v = 1'b0;

        if (slot_free) begin
            if (pick_found) begin
                take[pick_idx] = 1'b1;
                if (st_q.tbl[pick_idx] >= HW_LIM) begin
                    st_d.err.range = 1'b1;
                end else begin
                    st_d.out_v    = 1'b1;
                    st_d.out_code = st_q.tbl[pick_idx];
                end
            end else if (!f_empty && !lock_eff) begin
                fifo_pop      = 1'b1;
                st_d.out_v    = 1'b1;
                st_d.out_code = fifo_dout;
            end
        end

        st_d.pend = (st_q.pend & ~take) | (rise & ~st_q.pend);
        if (|(rise & st_q.pend)) st_d.err.lost = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.bound <= BOUND_RST;
            st_q.pp    <= PP_CODE_RST;
            st_q.ext   <= EXT_CODE_RST;
            for (int i = 0; i < N_IN; i++) st_q.tbl[i] <= code_t'(i);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr < A_TBL_END)     cfg_rdata = st_q.tbl[cfg_addr[IDX_W-1:0]];
        else if (cfg_addr == A_BOUND) cfg_rdata = st_q.bound;
        else if (cfg_addr == A_PP)    cfg_rdata = st_q.pp;
        else if (cfg_addr == A_EXT)   cfg_rdata = st_q.ext;
        else if (cfg_addr == A_ERR)   cfg_rdata = {5'b0, st_q.err};
        else if (cfg_addr == A_STAT)  cfg_rdata = {5'b0, st_q.lock, f_full, f_empty};
    end

    assign ev_valid       = st_q.out_v;
    assign ev_code        = st_q.out_code;
    assign lockout_active = st_q.lock;
    assign fifo_full      = f_full;
    assign fifo_empty     = f_empty;
    assign err_range      = st_q.err.range;
    assign err_fifo_val   = st_q.err.fval;
    assign err_lost       = st_q.err.lost;

    assign clr_lost = cfg_we && (cfg_addr == A_ERR) && cfg_wdata[2];

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_code))); // R12
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_lost) |-> $past(clr_lost)); // R11
    AST_LOCK_HOLDS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && !hs) |-> !fifo_pop); // R9
endmodule

// File: tb/tb_evt_prio_arbiter.sv
module tb_evt_prio_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] trig_in = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        ev_valid;
    logic [7:0]  ev_code;
    logic        ev_ready = 1'b0;
    logic        lockout_active, fifo_full, fifo_empty;
    logic        err_range, err_fifo_val, err_lost;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    evt_prio_arbiter dut (
        .clk (clk), .rst_n (rst_n), .trig_in (trig_in),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata), .ev_valid (ev_valid), .ev_code (ev_code),
        .ev_ready (ev_ready), .lockout_active (lockout_active),
        .fifo_full (fifo_full), .fifo_empty (fifo_empty),
        .err_range (err_range), .err_fifo_val (err_fifo_val), .err_lost (err_lost)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse(input logic [63:0] m);
        @(negedge clk);
        trig_in = trig_in | m;
        repeat (4) @(negedge clk);
        trig_in = trig_in & ~m;
        repeat (4) @(negedge clk);
    endtask

    task automatic get_ev(output logic [7:0] c, output bit ok);
        ok = 1'b0; c = '0;
        @(negedge clk);
        ev_ready = 1'b1;
        for (int k = 0; k < 40; k++) begin
            if (ev_valid) begin
                c = ev_code; ok = 1'b1;
                @(posedge clk);
                #1 ev_ready = 1'b0;
                break;
            end
            @(negedge clk);
        end
        ev_ready = 1'b0;
    endtask

    task automatic expect_ev(input logic [7:0] exp, input string req);
        logic [7:0] c;
        bit ok;
        get_ev(c, ok);
        chk(ok && c == exp, req, ok ? int'(c) : -1, int'(exp));
    endtask

    task automatic expect_none(input int n, input string req);
        bit seen = 1'b0;
        int c = -1;
        @(negedge clk);
        ev_ready = 1'b1;
        repeat (n) begin
            @(negedge clk);
            if (ev_valid && !seen) begin seen = 1'b1; c = int'(ev_code); end
        end
        ev_ready = 1'b0;
        chk(!seen, req, c, -1);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk(ev_valid == 1'b0, "R1 valid", ev_valid, 0);
        chk(fifo_empty && !fifo_full, "R1 fifo flags", {fifo_full, fifo_empty}, 1);
        chk(!lockout_active, "R1 lockout", lockout_active, 0);
        chk({err_range, err_fifo_val, err_lost} == 3'b0, "R1 errors",
            {err_range, err_fifo_val, err_lost}, 0);
        rd(8'd5, d);  chk(d == 8'd5, "R1 table[5]", d, 5);
        rd(8'd63, d); chk(d == 8'd63, "R1 table[63]", d, 63);
    endtask

    task automatic t_single();
        pulse(64'd1 << 7);
        expect_ev(8'd7, "R2 single");
        @(negedge clk); trig_in[11] = 1'b1;
        expect_ev(8'd11, "R2 held input");
        expect_none(15, "R2 no repeat while held");
        trig_in[11] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_priority();
        pulse((64'd1 << 40) | (64'd1 << 3) | (64'd1 << 20));
        expect_ev(8'd3,  "R3 first");
        expect_ev(8'd20, "R3 second");
        expect_ev(8'd40, "R3 third");
    endtask

    task automatic t_table();
        wr(8'd10, 8'h2A);
        pulse(64'd1 << 10);
        expect_ev(8'h2A, "R4 remapped code");
        wr(8'd10, 8'd10);
    endtask

    task automatic t_range();
        wr(8'd12, 8'h50);
        pulse(64'd1 << 12);
        expect_none(10, "R5 out-of-range dropped");
        chk(err_range, "R5 err_range", err_range, 1);
        wr(8'd12, 8'd12);
        pulse(64'd1 << 12);
        expect_ev(8'd12, "R5 pending cleared, input rearmed");
        wr(8'h44, 8'h02);
        chk(err_range, "R11 zero bit keeps flag", err_range, 1);
        wr(8'h44, 8'h01);
        @(negedge clk);
        chk(!err_range, "R11 range cleared", err_range, 0);
    endtask

    task automatic t_fifo();
        wr(8'h40, 8'h80);
        repeat (3) @(negedge clk);
        pulse(64'd1 << 2);
        wr(8'h40, 8'h81);
        expect_ev(8'h80, "R6 first queued");
        expect_ev(8'd2,  "R6 input beats queue");
        expect_ev(8'h81, "R6 queue order");
        @(negedge clk);
        chk(fifo_empty, "R8 empty after drain", fifo_empty, 1);
    endtask

    task automatic t_fifo_bad();
        wr(8'h40, 8'h3F);
        @(negedge clk);
        chk(err_fifo_val, "R7 err_fifo_val", err_fifo_val, 1);
        chk(fifo_empty, "R7 discarded", fifo_empty, 1);
        expect_none(8, "R7 nothing sent");
        wr(8'h44, 8'h02);
        @(negedge clk);
        chk(!err_fifo_val, "R11 fifo err cleared", err_fifo_val, 0);
    endtask

    task automatic t_full();
        wr(8'h40, 8'h90);
        repeat (3) @(negedge clk);
        for (int i = 1; i <= 16; i++) wr(8'h40, 8'(8'h90 + i));
        @(negedge clk);
        chk(fifo_full && !fifo_empty, "R8 full at 16", {fifo_full, fifo_empty}, 2);
        wr(8'h40, 8'hA1);
        for (int i = 0; i <= 16; i++) expect_ev(8'(8'h90 + i), "R8 drain order");
        expect_none(8, "R8 write when full ignored");
        chk(fifo_empty && !fifo_full, "R8 empty after drain", {fifo_full, fifo_empty}, 1);
        chk(!err_fifo_val, "R8 no value error", err_fifo_val, 0);
    endtask

    task automatic t_hold();
        pulse(64'd1 << 9);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(ev_valid && ev_code == 8'd9, "R12 held stable", ev_code, 9);
        end
        expect_ev(8'd9, "R12 accepted");
    endtask

    task automatic t_lost();
        pulse(64'd1 << 50);
        pulse(64'd1 << 51);
        pulse(64'd1 << 51);
        chk(err_lost, "R10 err_lost", err_lost, 1);
        expect_ev(8'd50, "R10 first");
        expect_ev(8'd51, "R10 single event");
        expect_none(10, "R10 retrigger dropped");
        wr(8'h44, 8'h04);
        @(negedge clk);
        chk(!err_lost, "R11 lost cleared", err_lost, 0);
    endtask

    task automatic t_lockout();
        wr(8'h41, 8'd8);
        wr(8'h42, 8'd4);
        wr(8'h43, 8'd5);
        pulse(64'd1 << 4);
        expect_ev(8'd4, "R9 pre-pulse");
        @(negedge clk);
        chk(lockout_active, "R9 lockout set", lockout_active, 1);
        pulse(64'd1 << 30);
        wr(8'h40, 8'hB0);
        expect_none(10, "R9 low and queue held");
        pulse(64'd1 << 6);
        expect_ev(8'd6, "R9 high-priority passes");
        pulse(64'd1 << 5);
        expect_ev(8'd5, "R9 extraction");
        @(negedge clk);
        chk(!lockout_active, "R9 lockout released", lockout_active, 0);
        expect_ev(8'd30, "R9 held input released");
        expect_ev(8'hB0, "R9 held queue released");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_priority();
        t_table();
        t_range();
        t_fifo();
        t_fifo_bad();
        t_full();
        t_hold();
        t_lost();
        t_lockout();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule